// File: doc/BRIEF.md
# Motor Driver Fault Supervisor

This block watches the fault indications of a four-bridge motor driver and decides when the power stage must be switched off. It receives one current-limit flag per bridge, an overtemperature flag, an undervoltage flag, and an active-low power-on reset. That reset stands for the motor supply being removed and then applied again. From these inputs it drives one disable line that turns off every bridge. It also drives a reset line for the command registers and the step indexer, and a three-bit cause field.

The three fault classes recover in different ways. A current-limit condition must last a set number of clock cycles before it counts as a fault. Once it counts, the shutdown stays in force until the next power-on reset. An overtemperature shutdown also stays in force until power-on reset, even after the temperature flag drops. Undervoltage disables the bridges only while it lasts. It also holds the command and indexer logic in reset, and operation resumes by itself when the supply recovers.

Top module: `mfault_supervisor`

## Requirements
- R1: Every fault input passes through a two-flop synchroniser. An undervoltage flag that rises between clock edges raises `bridges_off` after the second rising edge that follows, and not after the first.
- R2: If the OR of the current-limit flags stays high for `OC_PERSIST` consecutive clock edges, the overcurrent shutdown latches. A run of `OC_PERSIST-1` cycles does not latch it. The run may pass from one bridge's flag to another's without a break.
- R3: A single cycle in which no current-limit flag is high restarts the persistence count.
- R4: A latched overcurrent shutdown keeps `bridges_off` high after every current-limit flag has cleared. Only a low level on `por_n` clears it.
- R5: A high overtemperature flag latches the thermal shutdown. The shutdown stays after the flag clears, and only `por_n` low clears it.
- R6: While the synchronised undervoltage flag is high, `bridges_off` is high. When that flag clears and no latched fault is present, `bridges_off` returns low with no further action.
- R7: `ctrl_reset` is high while `por_n` is low. It is also high from the third rising edge after the undervoltage flag rises until the third rising edge after it falls.
- R8: `fault_cause` bit 0 reports the latched overcurrent shutdown, bit 1 the latched thermal shutdown and bit 2 the present undervoltage. Several bits may be set together, and `bridges_off` is high whenever any of the bits is set. All bits are clear after power-on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| ilim_flag | input | NUM_BRIDGES | Analog current-limit flag, one per bridge |
| overtemp_flag | input | 1 | Die overtemperature flag |
| undervolt_flag | input | 1 | Motor supply undervoltage flag |
| bridges_off | output | 1 | Disable for all bridges |
| ctrl_reset | output | 1 | Reset for command registers and indexer |
| fault_cause | output | 3 | Cause of shutdown: bit0 overcurrent, bit1 thermal, bit2 undervoltage |

## Verification
The persistence filter is driven with current-limit runs of exactly `OC_PERSIST-1` and `OC_PERSIST` cycles. These two runs show the precise threshold. A near-threshold run broken by one clear cycle shows that the count restarts. A run that hands over from bridge 0 to bridge 3 shows that the flags are combined by OR. Undervoltage pulses are sampled edge by edge to fix the two-flop latency and the one-cycle lag of the reset line. They also show that the bridges come back on their own. An undervoltage that overlaps a thermal fault, and a thermal fault that outlives its flag, show which shutdowns stick and which release, each up to the next power-on reset.

// File: rtl/mfault_supervisor.sv
module mfault_supervisor #(
  parameter int NUM_BRIDGES = 4,
  parameter int OC_PERSIST  = 16
) (
  input  logic                   clk,
  input  logic                   por_n,
  input  logic [NUM_BRIDGES-1:0] ilim_flag,
  input  logic                   overtemp_flag,
  input  logic                   undervolt_flag,
  output logic                   bridges_off,
  output logic                   ctrl_reset,
  output logic [2:0]             fault_cause
);

  localparam int NRAW = NUM_BRIDGES + 2;
  localparam int CW   = (OC_PERSIST > 2) ? $clog2(OC_PERSIST) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(OC_PERSIST - 1);

  logic [NRAW-1:0] meta_q, sync_q;
  logic [CW-1:0]   oc_cnt;
  logic            oc_latch, ot_latch;
  logic            oc_any_s, ot_s, uv_s;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= {undervolt_flag, overtemp_flag, ilim_flag};
      sync_q <= meta_q;
    end

  assign oc_any_s = |sync_q[NUM_BRIDGES-1:0];
  assign ot_s     = sync_q[NUM_BRIDGES];
  assign uv_s     = sync_q[NUM_BRIDGES+1];

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)               oc_cnt <= '0;
    else if (!oc_any_s)       oc_cnt <= '0;
    else if (oc_cnt != CNT_LAST) oc_cnt <= oc_cnt + 1'b1;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      oc_latch   <= 1'b0;
      ot_latch   <= 1'b0;
      ctrl_reset <= 1'b1;
    end else begin
      if (oc_any_s && oc_cnt == CNT_LAST) oc_latch <= 1'b1;
      if (ot_s) ot_latch <= 1'b1;
      ctrl_reset <= uv_s;
    end

  assign fault_cause = {uv_s, ot_latch, oc_latch};
  assign bridges_off = oc_latch | ot_latch | uv_s;

endmodule

// File: rtl/mfault_supervisor_chk.sv
module mfault_supervisor_chk #(
  parameter int OC_PERSIST = 16
) (
  input logic       clk,
  input logic       por_n,
  input logic       oc_any_s,
  input logic       bridges_off,
  input logic       ctrl_reset,
  input logic [2:0] fault_cause
);

  int unsigned run_len;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)        run_len <= 0;
    else if (!oc_any_s) run_len <= 0;
    else if (run_len < 32'hFFFF_0000) run_len <= run_len + 1;

  a_r2_oc_needs_run: assert property (@(posedge clk) disable iff (!por_n)
    $rose(fault_cause[0]) |-> (run_len >= OC_PERSIST));

  a_r4_oc_sticky: assert property (@(posedge clk) disable iff (!por_n)
    fault_cause[0] |=> fault_cause[0]);

  a_r5_ot_sticky: assert property (@(posedge clk) disable iff (!por_n)
    fault_cause[1] |=> fault_cause[1]);

  a_r6_uv_release: assert property (@(posedge clk) disable iff (!por_n)
    ($fell(fault_cause[2]) && fault_cause[1:0] == 2'b00) |-> !bridges_off);

  a_r7_reset_follows_uv: assert property (@(posedge clk) disable iff (!por_n)
    (ctrl_reset && $past(por_n)) |-> $past(fault_cause[2]));

  a_r8_off_when_cause: assert property (@(posedge clk) disable iff (!por_n)
    (fault_cause != 3'b000) |-> bridges_off);

endmodule

bind mfault_supervisor mfault_supervisor_chk #(.OC_PERSIST(OC_PERSIST)) chk_i (
  .clk(clk),
  .por_n(por_n),
  .oc_any_s(oc_any_s),
  .bridges_off(bridges_off),
  .ctrl_reset(ctrl_reset),
  .fault_cause(fault_cause)
);

// File: tb/mfault_supervisor_tb_top.sv
`timescale 1ns/1ps
module mfault_supervisor_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 4;
  localparam int P  = 12;

  logic          clk = 1'b0;
  logic          por_n;
  logic [NB-1:0] ilim;
  logic          ot, uv;
  logic          off, crst;
  logic [2:0]    cause;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mfault_supervisor #(.NUM_BRIDGES(NB), .OC_PERSIST(P)) dut_i (
    .clk(clk), .por_n(por_n), .ilim_flag(ilim), .overtemp_flag(ot),
    .undervolt_flag(uv), .bridges_off(off), .ctrl_reset(crst), .fault_cause(cause)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {off, crst, cause};
  endfunction

  task automatic power_cycle();
    @(negedge clk);
    ilim = '0; ot = 0; uv = 0; por_n = 0;
    step(3);
    check("R8 reset state", outs(), 5'b01000);
    por_n = 1;
    step(2);
    check("R8 idle after reset", outs(), 5'b00000);
  endtask

  task automatic oc_run(input int b, input int n);
    ilim[b] = 1'b1;
    step(n);
    ilim[b] = 1'b0;
    step(4);
  endtask

  task automatic t_oc_threshold();
    power_cycle();
    oc_run(1, P-1);
    check("R2 short run no latch", outs(), 5'b00000);
    oc_run(2, P);
    check("R2 full run latches", outs(), 5'b10001);
    step(20);
    check("R4 oc stays after flags clear", outs(), 5'b10001);
  endtask

  task automatic t_oc_restart();
    power_cycle();
    ilim[0] = 1'b1; step(P-1);
    ilim[0] = 1'b0; step(1);
    ilim[0] = 1'b1; step(P-1);
    ilim[0] = 1'b0; step(4);
    check("R3 broken run restarts count", outs(), 5'b00000);
  endtask

  task automatic t_oc_handoff();
    power_cycle();
    ilim[0] = 1'b1; step(4);
    ilim[3] = 1'b1; step(1);
    ilim[0] = 1'b0; step(P-5);
    ilim[3] = 1'b0; step(4);
    check("R2 handoff between bridges latches", outs(), 5'b10001);
    power_cycle();
    check("R4 power cycle clears oc", outs(), 5'b00000);
  endtask

  task automatic t_uv_timing();
    power_cycle();
    uv = 1'b1;
    step(1);
    check("R1 uv not seen after one edge", outs(), 5'b00000);
    step(1);
    check("R1 uv seen after two edges", outs(), 5'b10100);
    step(1);
    check("R7 ctrl_reset one edge later", outs(), 5'b11100);
    step(5);
    uv = 1'b0;
    step(2);
    check("R6 uv releases bridges", outs(), 5'b01000);
    step(1);
    check("R7 ctrl_reset drops", outs(), 5'b00000);
  endtask

  task automatic t_ot_combo();
    power_cycle();
    ot = 1'b1; step(1);
    ot = 1'b0; step(3);
    check("R5 short ot pulse latches", outs(), 5'b10010);
    uv = 1'b1; step(3);
    check("R8 thermal and uv together", outs(), 5'b11110);
    uv = 1'b0; step(3);
    check("R5 ot holds after uv clears", outs(), 5'b10010);
    step(10);
    check("R5 ot still latched", outs(), 5'b10010);
    power_cycle();
    check("R5 power cycle clears ot", outs(), 5'b00000);
  endtask

  initial begin
    por_n = 0; ilim = '0; ot = 0; uv = 0;
    t_oc_threshold();
    t_oc_restart();
    t_oc_handoff();
    t_uv_timing();
    t_ot_combo();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule